// File: doc/BRIEF.md
# Self-Programming Command Arm Controller

This block holds the five-bit command register that a small processor core uses to program its own flash. Software writes a command pattern, and the block arms it for a short window. If the CPU's store-to-program-memory strobe arrives inside that window, the armed command runs. The command can load one 16-bit word into the temporary page buffer, erase a page or program a page. If no strobe arrives in time, the command lapses on its own.

Page erase and page write go to the flash array as a start pulse that carries an operation code and a latched page number. The array answers with a done pulse after a variable number of cycles. Until that pulse arrives, the block reports busy and keeps the enable bit set. It ignores any further register writes. It also holds a halt request towards the CPU when the target page is at or above a boundary page. A boundary parameter marks the start of the protected no-read-while-write region. The 16-bit pointer is split into fields: bit 0 is ignored, bits 5:1 select a word inside a 32-word page, and the bits above select the page.

Top module: `spm_arm_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `ctrl_q`, `busy`, `cpu_halt`, `fl_start` and `buf_we` are all zero.
- R2: The bits of `ctrl_q` are: bit0 enable, bit1 erase, bit2 write, bit3 aux-A, bit4 aux-B. A write of one of the patterns 5'b00001, 5'b00011, 5'b00101, 5'b01001 or 5'b10001 loads that pattern into `ctrl_q` one cycle later. A write of any other pattern leaves `ctrl_q` unchanged.
- R3: After an accepted write, a strobe sampled on any of the next four rising edges runs the command. If those four edges pass with no strobe, `ctrl_q` returns to zero at the fourth edge.
- R4: An armed 5'b00001 plus a strobe gives a one-cycle `buf_we` pulse. The pulse carries `buf_widx` = `ptr[5:1]` and `buf_wdata` = `data_in`. `ctrl_q` clears at the same edge.
- R5: An armed 5'b00011 or 5'b00101 plus a strobe gives a one-cycle `fl_start` pulse. `fl_op` is 2'b01 for erase and 2'b10 for write, and `fl_page` = `ptr[15:6]`. `busy` rises at the same edge. `data_in` plays no part.
- R6: While `busy` is high, `ctrl_q` keeps its value with the enable bit set. At the edge that samples `fl_done`, both `busy` and `ctrl_q` return to zero.
- R7: `fl_page` keeps the value captured at the start for the whole operation, whatever `ptr` does afterwards.
- R8: `cpu_halt` is high for exactly the cycles of `busy` when the latched page is at or above `NRWW_FIRST_PAGE` (default 896). Otherwise it stays low.
- R9: Register writes and strobes that arrive while `busy` is high have no effect. A `fl_done` that arrives while not busy has no effect.
- R10: An armed aux pattern (5'b01001 or 5'b10001) plus a strobe clears `ctrl_q` and produces neither `buf_we` nor `fl_start`.
- R11: A strobe that arrives while `ctrl_q` is zero has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 5 | Command pattern being written |
| spm_strobe | input | 1 | Store-to-program-memory strobe from the CPU |
| ptr | input | 16 | Address pointer (word and page fields) |
| data_in | input | 16 | Data word for buffer fill |
| fl_done | input | 1 | Flash array completion pulse |
| ctrl_q | output | 5 | Command register contents |
| busy | output | 1 | Erase or write in progress |
| cpu_halt | output | 1 | Halt request to the CPU |
| fl_start | output | 1 | One-cycle erase/write start pulse |
| fl_op | output | 2 | Operation code, 01 erase, 10 write |
| fl_page | output | 10 | Latched page number |
| buf_we | output | 1 | Page buffer write pulse |
| buf_widx | output | 5 | Buffer word index |
| buf_wdata | output | 16 | Buffer word data |

## Verification
The assertions assume that the flash array raises `fl_done` only after a started operation. They also assume that `fl_done` lasts a single cycle. They put no rule on strobes or register writes during busy, because the design must ignore those. The stimulus drives `fl_done` only after a start and never in the start cycle itself. It also sends stray done pulses while idle, and writes and strobes while busy, on purpose, so that the ignore rules are exercised. A behavioural model in the bench follows the same window, latching and completion rules and is compared with every output on every cycle.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int CMD_W     = 5;
  localparam int EN_BIT    = 0;
  localparam int ERASE_BIT = 1;
  localparam int WRITE_BIT = 2;
  localparam int AUXA_BIT  = 3;
  localparam int AUXB_BIT  = 4;

  typedef enum logic [1:0] {
    FOP_NONE  = 2'b00,
    FOP_ERASE = 2'b01,
    FOP_WRITE = 2'b10
  } flash_op_e;

  typedef enum logic [2:0] {
    CK_NONE,
    CK_FILL,
    CK_ERASE,
    CK_WRITE,
    CK_AUX
  } cmd_kind_e;
endpackage

// File: rtl/spm_cmd_decode.sv
module spm_cmd_decode
  import spm_pkg::*;
(
  input  logic [CMD_W-1:0] pattern,
  output logic             legal,
  output cmd_kind_e        kind
);
  // Accepted patterns: enable alone, or enable plus exactly one companion bit
  always_comb begin
    legal = 1'b0;
    kind  = CK_NONE;
    if (pattern[EN_BIT]) begin
      unique case (pattern[CMD_W-1:1])
        4'b0000: begin legal = 1'b1; kind = CK_FILL;  end
        4'b0001: begin legal = 1'b1; kind = CK_ERASE; end
        4'b0010: begin legal = 1'b1; kind = CK_WRITE; end
        4'b0100,
        4'b1000: begin legal = 1'b1; kind = CK_AUX;   end
        default: begin legal = 1'b0; kind = CK_NONE;  end
      endcase
    end
  end
endmodule

// File: rtl/spm_arm_timer.sv
module spm_arm_timer #(
  parameter int ARM_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic expire
);
  localparam int CNT_W = $clog2(ARM_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  assign expire = tick && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CNT_W'(ARM_CYCLES);
    end else if (tick && cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/spm_addr_split.sv
module spm_addr_split #(
  parameter int PTR_W           = 16,
  parameter int PAGE_WORDS      = 32,
  parameter int NRWW_FIRST_PAGE = 896,
  localparam int WIDX_W = $clog2(PAGE_WORDS),
  localparam int PAGE_W = PTR_W - 1 - WIDX_W
) (
  input  logic [PTR_W-1:1]  ptr_hi,
  output logic [WIDX_W-1:0] word_idx,
  output logic [PAGE_W-1:0] page_idx,
  output logic              in_nrww
);
  assign word_idx = ptr_hi[WIDX_W:1];
  assign page_idx = ptr_hi[PTR_W-1:WIDX_W+1];
  assign in_nrww  = page_idx >= PAGE_W'(NRWW_FIRST_PAGE);
endmodule

// File: rtl/spm_arm_ctrl.sv
module spm_arm_ctrl
  import spm_pkg::*;
#(
  parameter int PTR_W           = 16,
  parameter int DATA_W          = 16,
  parameter int PAGE_WORDS      = 32,
  parameter int NRWW_FIRST_PAGE = 896,
  parameter int ARM_CYCLES      = 4,
  localparam int WIDX_W = $clog2(PAGE_WORDS),
  localparam int PAGE_W = PTR_W - 1 - WIDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic              spm_strobe,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              fl_done,
  output logic [CMD_W-1:0]  ctrl_q,
  output logic              busy,
  output logic              cpu_halt,
  output logic              fl_start,
  output logic [1:0]        fl_op,
  output logic [PAGE_W-1:0] fl_page,
  output logic              buf_we,
  output logic [WIDX_W-1:0] buf_widx,
  output logic [DATA_W-1:0] buf_wdata
);
  logic      wr_legal, armed_legal;
  cmd_kind_e wr_kind, armed_kind;
  logic      wr_ok, armed, tick, expire;
  logic [WIDX_W-1:0] word_idx;
  logic [PAGE_W-1:0] page_idx;
  logic      in_nrww;
  logic      unused_ptr_lsb;

  assign unused_ptr_lsb = ptr[0];

  spm_cmd_decode u_wr_dec (
    .pattern (cmd_wdata),
    .legal   (wr_legal),
    .kind    (wr_kind)
  );

  spm_cmd_decode u_arm_dec (
    .pattern (ctrl_q),
    .legal   (armed_legal),
    .kind    (armed_kind)
  );

  spm_addr_split #(
    .PTR_W           (PTR_W),
    .PAGE_WORDS      (PAGE_WORDS),
    .NRWW_FIRST_PAGE (NRWW_FIRST_PAGE)
  ) u_split (
    .ptr_hi   (ptr[PTR_W-1:1]),
    .word_idx (word_idx),
    .page_idx (page_idx),
    .in_nrww  (in_nrww)
  );

  assign wr_ok = cmd_wr && wr_legal && !busy && (wr_kind != CK_NONE);
  assign armed = ctrl_q[EN_BIT] && armed_legal && !busy;
  assign tick  = armed && !wr_ok && !spm_strobe;

  spm_arm_timer #(.ARM_CYCLES(ARM_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (wr_ok),
    .tick   (tick),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      busy      <= 1'b0;
      cpu_halt  <= 1'b0;
      fl_start  <= 1'b0;
      fl_op     <= FOP_NONE;
      fl_page   <= '0;
      buf_we    <= 1'b0;
      buf_widx  <= '0;
      buf_wdata <= '0;
    end else begin
      fl_start <= 1'b0;
      buf_we   <= 1'b0;
      if (busy) begin
        if (fl_done) begin
          busy     <= 1'b0;
          cpu_halt <= 1'b0;
          ctrl_q   <= '0;
          fl_op    <= FOP_NONE;
        end
      end else if (wr_ok) begin
        ctrl_q <= cmd_wdata;
      end else if (armed) begin
        if (spm_strobe) begin
          unique case (armed_kind)
            CK_FILL: begin
              buf_we    <= 1'b1;
              buf_widx  <= word_idx;
              buf_wdata <= data_in;
              ctrl_q    <= '0;
            end
            CK_ERASE, CK_WRITE: begin
              fl_start <= 1'b1;
              fl_op    <= (armed_kind == CK_ERASE) ? FOP_ERASE : FOP_WRITE;
              fl_page  <= page_idx;
              busy     <= 1'b1;
              cpu_halt <= in_nrww;
            end
            default: ctrl_q <= '0;
          endcase
        end else if (expire) begin
          ctrl_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/spm_arm_ctrl_chk.sv
module spm_arm_ctrl_chk #(
  parameter int ARM_CYCLES = 4,
  parameter int PAGE_W     = 10,
  parameter int WIDX_W     = 5,
  parameter int DATA_W     = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_wr,
  input logic [4:0]        ctrl_q,
  input logic              busy,
  input logic              cpu_halt,
  input logic              fl_start,
  input logic [1:0]        fl_op,
  input logic [PAGE_W-1:0] fl_page,
  input logic              fl_done,
  input logic              buf_we
);
  int idle_armed_cnt;

  always_ff @(posedge clk) begin
    if (rst || cmd_wr) idle_armed_cnt <= 0;
    else if (ctrl_q != 5'b0 && !busy) idle_armed_cnt <= idle_armed_cnt + 1;
    else idle_armed_cnt <= 0;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (ctrl_q == 5'b0 && !busy && !cpu_halt && !fl_start && !buf_we));

  p_window_len_r3: assert property (@(posedge clk) disable iff (rst)
    idle_armed_cnt <= ARM_CYCLES);

  p_fill_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    buf_we |=> !buf_we);

  p_fill_clears_r4: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> (ctrl_q == 5'b0 && !busy));

  p_start_op_r5: assert property (@(posedge clk) disable iff (rst)
    fl_start |-> (busy && (fl_op == 2'b01 || fl_op == 2'b10)));

  p_busy_from_start_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> fl_start);

  p_enable_held_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> ctrl_q[0]);

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !fl_done) |=> busy);

  p_done_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && fl_done) |=> (!busy && ctrl_q == 5'b0 && !cpu_halt));

  p_page_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !fl_start) |-> $stable(fl_page));

  p_halt_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
    cpu_halt |-> busy);

  p_ctrl_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !fl_done) |=> $stable(ctrl_q));
endmodule

bind spm_arm_ctrl spm_arm_ctrl_chk #(
  .ARM_CYCLES (ARM_CYCLES),
  .PAGE_W     (PAGE_W),
  .WIDX_W     (WIDX_W),
  .DATA_W     (DATA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_wr   (cmd_wr),
  .ctrl_q   (ctrl_q),
  .busy     (busy),
  .cpu_halt (cpu_halt),
  .fl_start (fl_start),
  .fl_op    (fl_op),
  .fl_page  (fl_page),
  .fl_done  (fl_done),
  .buf_we   (buf_we)
);

// File: tb/tb_spm_arm_ctrl.sv
module tb_spm_arm_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [4:0]  cmd_wdata = '0;
  logic        spm_strobe = 1'b0;
  logic [15:0] ptr = '0;
  logic [15:0] data_in = '0;
  logic        fl_done = 1'b0;
  logic [4:0]  ctrl_q;
  logic        busy, cpu_halt, fl_start, buf_we;
  logic [1:0]  fl_op;
  logic [9:0]  fl_page;
  logic [4:0]  buf_widx;
  logic [15:0] buf_wdata;

  always #2 clk = ~clk;

  spm_arm_ctrl dut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .spm_strobe(spm_strobe), .ptr(ptr), .data_in(data_in), .fl_done(fl_done),
    .ctrl_q(ctrl_q), .busy(busy), .cpu_halt(cpu_halt), .fl_start(fl_start),
    .fl_op(fl_op), .fl_page(fl_page), .buf_we(buf_we), .buf_widx(buf_widx),
    .buf_wdata(buf_wdata)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;

  // Reference model state
  int        m_ctrl, m_win, m_busy, m_halt, m_start, m_op, m_page;
  int        m_we, m_widx, m_wdata;

  function automatic bit legal(int v);
    return v == 1 || v == 3 || v == 5 || v == 9 || v == 17;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_ctrl = 0; m_win = 0; m_busy = 0; m_halt = 0; m_start = 0;
      m_op = 0; m_page = 0; m_we = 0; m_widx = 0; m_wdata = 0;
    end else begin
      m_start = 0; m_we = 0;
      if (m_busy != 0) begin
        if (fl_done) begin m_busy = 0; m_halt = 0; m_ctrl = 0; m_op = 0; end
      end else if (cmd_wr && legal(int'(cmd_wdata))) begin
        m_ctrl = int'(cmd_wdata); m_win = 4;
      end else if (m_ctrl != 0) begin
        if (spm_strobe) begin
          if (m_ctrl == 1) begin
            m_we = 1; m_widx = (int'(ptr) >> 1) % 32; m_wdata = int'(data_in); m_ctrl = 0;
          end else if (m_ctrl == 3 || m_ctrl == 5) begin
            m_start = 1; m_op = (m_ctrl == 3) ? 1 : 2; m_page = int'(ptr) / 64;
            m_busy = 1; m_halt = (m_page >= 896) ? 1 : 0;
          end else m_ctrl = 0;
        end else begin
          m_win = m_win - 1;
          if (m_win == 0) m_ctrl = 0;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R3 ctrl_q", int'(ctrl_q), m_ctrl);
      chk("R6 busy", int'(busy), m_busy);
      chk("R8 cpu_halt", int'(cpu_halt), m_halt);
      chk("R5 fl_start", int'(fl_start), m_start);
      chk("R4 buf_we", int'(buf_we), m_we);
      if (m_start != 0) chk("R5 fl_op", int'(fl_op), m_op);
      if (m_busy != 0) chk("R7 fl_page", int'(fl_page), m_page);
      if (m_we != 0) begin
        chk("R4 buf_widx", int'(buf_widx), m_widx);
        chk("R4 buf_wdata", int'(buf_wdata), m_wdata);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int v);
    cmd_wr = 1'b1; cmd_wdata = 5'(v);
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic strobe(int p, int d);
    spm_strobe = 1'b1; ptr = 16'(p); data_in = 16'(d);
    @(negedge clk);
    spm_strobe = 1'b0;
  endtask

  task automatic done_pulse();
    fl_done = 1'b1;
    @(negedge clk);
    fl_done = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cycles > 100000 && !finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      summary();
    end
  end

  initial begin
    idle(3);
    chk("R1 ctrl_q in reset", int'(ctrl_q), 0);
    chk("R1 busy in reset", int'(busy), 0);
    rst = 1'b0;
    idle(1);
    chk("R1 outputs after reset", int'({ctrl_q, busy, cpu_halt, fl_start, buf_we}), 0);

    // R2: accepted patterns load the register
    for (int v = 0; v < 32; v++) begin
      wr(v);
      chk("R2 pattern load", int'(ctrl_q), legal(v) ? v : 0);
      idle(5);
    end

    // R4: buffer fill inside window
    wr(1); idle(1);
    strobe(16'h1234, 16'hBEEF);
    chk("R4 fill pulse", int'(buf_we), 1);
    chk("R4 fill index", int'(buf_widx), 5'h1A);
    chk("R4 fill clears", int'(ctrl_q), 0);

    // R3: strobe on fourth edge acts, fifth edge ignored
    wr(1); idle(3);
    strobe(16'h0003, 16'h5A5A);
    chk("R3 fourth edge fill", int'(buf_we), 1);
    wr(1); idle(4);
    chk("R3 window lapsed", int'(ctrl_q), 0);
    strobe(16'h0004, 16'h1111);
    chk("R3 late strobe", int'(buf_we), 0);

    // R2: illegal write while armed leaves register
    wr(1); wr(7);
    chk("R2 illegal while armed", int'(ctrl_q), 1);
    idle(4);

    // R5: erase of a low page, R7 pointer changes ignored
    wr(3);
    strobe(16'h0040, 16'hAAAA);
    chk("R5 erase start", int'(fl_start), 1);
    chk("R5 erase op", int'(fl_op), 1);
    chk("R5 erase page", int'(fl_page), 1);
    chk("R8 no halt low page", int'(cpu_halt), 0);
    ptr = 16'hFFFF;
    idle(5);
    chk("R7 page held", int'(fl_page), 1);
    chk("R6 enable held", int'(ctrl_q), 3);
    done_pulse();
    chk("R6 done clears busy", int'(busy), 0);
    chk("R6 done clears ctrl", int'(ctrl_q), 0);

    // R8 and R9: write of high page, writes and strobes during busy
    wr(5);
    strobe(16'hFFC0, 16'h0);
    chk("R8 halt high page", int'(cpu_halt), 1);
    chk("R5 write op", int'(fl_op), 2);
    wr(1);
    chk("R9 write ignored in busy", int'(ctrl_q), 5);
    strobe(16'h0002, 16'h2222);
    chk("R9 strobe ignored in busy", int'(buf_we), 0);
    idle(3);
    done_pulse();
    chk("R8 halt released", int'(cpu_halt), 0);

    // R8 boundary pages 895 and 896
    wr(3); strobe(16'hDFC0, 0);
    chk("R8 page 895 no halt", int'(cpu_halt), 0);
    idle(2); done_pulse();
    wr(3); strobe(16'hE000, 0);
    chk("R8 page 896 halt", int'(cpu_halt), 1);
    idle(1); done_pulse();

    // R9: stray done while idle
    done_pulse();
    chk("R9 stray done", int'(busy), 0);

    // R10: aux patterns consumed without action
    wr(17); strobe(16'h0100, 16'h3333);
    chk("R10 aux-B consumed", int'({ctrl_q, fl_start, buf_we}), 0);
    wr(9); idle(2); strobe(16'h0100, 16'h3333);
    chk("R10 aux-A consumed", int'({ctrl_q, fl_start, buf_we}), 0);

    // R11: strobe with nothing armed
    strobe(16'h0044, 16'h4444);
    chk("R11 idle strobe", int'({ctrl_q, busy, fl_start, buf_we}), 0);

    // R1: reset during busy
    wr(5); strobe(16'hFFC0, 0);
    rst = 1'b1; idle(1); rst = 1'b0;
    chk("R1 reset mid-operation", int'({ctrl_q, busy, cpu_halt}), 0);
    idle(3);
    summary();
  end
endmodule